// File: doc/BRIEF.md
# Dual Limit Timer

This unit holds two independent 32-bit timers behind a single-cycle register port. Each timer owns a count, a limit and a control register. On every enabled cycle the count steps up by one. When the count already equals the limit, the next step reloads it to zero instead. That reload also sets a sticky event flag, so a periodic tick keeps running without software touching the count.

Two control bits drive each timer. One bit gates the event flag onto the timer's interrupt line. The other bit freezes the count while the halted input is high. Software acknowledges an event by writing the control register; the value written does not matter.

Reads are combinational from the address: `rdata_o` shows the addressed register in the same cycle. Writes take effect at the next rising clock edge.

Top module: `pdt_dual_timer`

## Requirements
- R1: Timer 0 count, control and limit sit at addresses 0x021, 0x022 and 0x023. Timer 1 count, control and limit sit at 0x100, 0x101 and 0x102. After reset every count reads 0, every control reads 0, every limit reads 0xFFFFFFFF, and `irq_o` is 0.
- R2: An enabled timer whose count differs from its limit adds one to the count on each clock. A write to the count loads `wdata_i` and overrides that cycle's step or reload, and the overridden reload sets no flag.
- R3: An enabled timer whose count equals its limit reloads the count to 0 on the next clock and sets its event flag. With the limit at 0xFFFFFFFF the count runs freely and wraps from 0xFFFFFFFF to 0.
- R4: Control bit 1 is the halt-gating mode. While it is 1 and `halted_i` is 1, the count holds. While it is 0, `halted_i` has no effect.
- R5: The event flag is sticky: it stays set on later cycles until acknowledged. `irq_o[t]` equals the flag ANDed with control bit 0 of timer t.
- R6: Any write to a timer's control register clears that timer's flag, whatever the data. The clear wins over a reload in the same cycle.
- R7: A control read returns bits 1:0 as last written and zero in bits 31:2. A read of any other unmapped address returns 0.
- R8: Writes, flags and counting of one timer never affect the other timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register address |
| we_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| halted_i | input | 1 | CPU halted indication |
| irq_o | output | 2 | Interrupt per timer, bit t for timer t |

## Verification
The in-line properties check the following on every cycle:
- a count load lands in the next cycle;
- an enabled step adds exactly one;
- an equal count reloads to zero;
- a gated timer holds;
- the flag stays set until a control write, which always clears it;
- the read mux returns zeros off the map and above the two control bits.

Only the bench scenarios can show the things that span several registers or time:
- the absolute address map and reset values;
- the end-to-end period for a given limit;
- masking of the flag by the enable bit;
- a count above the limit running on past it;
- the clear winning over a same-cycle reload;
- the two timers staying apart while both are active.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int CTRL_W   = 2;
  localparam int OFF_CNT  = 0;
  localparam int OFF_CTRL = 1;
  localparam int OFF_LIM  = 2;
  localparam int REGS_PER = 3;

  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_CTRL = 2'd1,
    REG_LIM  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // bit 1: halt gating, bit 0: interrupt enable
  typedef struct packed {
    logic nh;
    logic ie;
  } ctrl_t;
endpackage

// File: rtl/pdt_decode.sv
module pdt_decode
  import pdt_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_TMR = 2,
  parameter logic [NUM_TMR*ADDR_W-1:0] BASES = {12'h100, 12'h021},
  parameter int IDX_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  output logic [NUM_TMR-1:0] hit_o,
  output logic [NUM_TMR-1:0] we_cnt_o,
  output logic [NUM_TMR-1:0] we_ctrl_o,
  output logic [NUM_TMR-1:0] we_lim_o,
  output reg_sel_e           sel_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [ADDR_W-1:0] off_w [NUM_TMR];

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_dec
    assign off_w[t]     = addr_i - BASES[t*ADDR_W +: ADDR_W];
    assign hit_o[t]     = off_w[t] < ADDR_W'(REGS_PER);
    assign we_cnt_o[t]  = we_i && hit_o[t] && (off_w[t] == ADDR_W'(OFF_CNT));
    assign we_ctrl_o[t] = we_i && hit_o[t] && (off_w[t] == ADDR_W'(OFF_CTRL));
    assign we_lim_o[t]  = we_i && hit_o[t] && (off_w[t] == ADDR_W'(OFF_LIM));
  end

  always_comb begin
    sel_o = REG_NONE;
    idx_o = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (hit_o[t]) begin
        sel_o = reg_sel_e'(off_w[t][1:0]);
        idx_o = IDX_W'(t);
      end
    end
  end
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_cnt_i,
  input  logic              we_ctrl_i,
  input  logic              we_lim_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              halted_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] lim_o,
  output ctrl_t             ctrl_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q, lim_q;
  ctrl_t             ctrl_q;
  logic              flag_q;
  logic              advance, at_lim;

  assign advance = !(ctrl_q.nh && halted_i);
  assign at_lim  = (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (we_cnt_i) cnt_q <= wdata_i;
    else if (advance)  cnt_q <= at_lim ? '0 : cnt_q + DATA_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lim_q <= '1;
    else if (we_lim_i) lim_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (we_ctrl_i) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  // ack beats a same-cycle reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              flag_q <= 1'b0;
    else if (we_ctrl_i)                       flag_q <= 1'b0;
    else if (!we_cnt_i && advance && at_lim)  flag_q <= 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = flag_q & ctrl_q.ie;

  p_cnt_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_cnt_i |=> cnt_q == $past(wdata_i));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_cnt_i && advance && !at_lim) |=> cnt_q == $past(cnt_q) + DATA_W'(1));
  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_cnt_i && advance && at_lim) |=> cnt_q == '0);
  p_gate_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_cnt_i && ctrl_q.nh && halted_i) |=> $stable(cnt_q));
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !we_ctrl_i) |=> flag_q);
  p_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_ctrl_i |=> !flag_q);
endmodule

// File: rtl/pdt_dual_timer.sv
module pdt_dual_timer
  import pdt_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int NUM_TMR = 2,
  parameter logic [NUM_TMR*ADDR_W-1:0] BASES = {12'h100, 12'h021}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               halted_i,
  output logic [NUM_TMR-1:0] irq_o
);
  localparam int IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

  logic [NUM_TMR-1:0] hit, we_cnt, we_ctrl, we_lim;
  reg_sel_e           sel;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  cnt_w [NUM_TMR];
  logic [DATA_W-1:0]  lim_w [NUM_TMR];
  ctrl_t              ctrl_w [NUM_TMR];

  pdt_decode #(
    .ADDR_W (ADDR_W),
    .NUM_TMR(NUM_TMR),
    .BASES  (BASES),
    .IDX_W  (IDX_W)
  ) u_dec (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .hit_o    (hit),
    .we_cnt_o (we_cnt),
    .we_ctrl_o(we_ctrl),
    .we_lim_o (we_lim),
    .sel_o    (sel),
    .idx_o    (idx)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    pdt_timer #(.DATA_W(DATA_W)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_cnt_i (we_cnt[t]),
      .we_ctrl_i(we_ctrl[t]),
      .we_lim_i (we_lim[t]),
      .wdata_i  (wdata_i),
      .halted_i (halted_i),
      .cnt_o    (cnt_w[t]),
      .lim_o    (lim_w[t]),
      .ctrl_o   (ctrl_w[t]),
      .irq_o    (irq_o[t])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (|hit) begin
      unique case (sel)
        REG_CNT:  rdata_o = cnt_w[idx];
        REG_CTRL: rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_w[idx]};
        REG_LIM:  rdata_o = lim_w[idx];
        default:  rdata_o = '0;
      endcase
    end
  end

  p_one_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  p_unmapped_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|hit) |-> rdata_o == '0);
  p_ctrl_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == REG_CTRL) |-> rdata_o[DATA_W-1:CTRL_W] == '0);
endmodule

// File: tb/sim_pdt_dual_timer.sv
module sim_pdt_dual_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] T0 = 12'h021;
  localparam logic [11:0] T1 = 12'h100;

  typedef struct packed {
    logic        tmr;
    logic [31:0] lim;
    logic [31:0] cnt;
    logic        ie;
    logic        run;
    logic [7:0]  n;
    logic [31:0] exp_cnt;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 32'd10,         32'd3,          1'b1, 1'b1, 8'd5,  32'd8, 1'b0},
    '{1'b0, 32'd10,         32'd8,          1'b1, 1'b1, 8'd4,  32'd1, 1'b1},
    '{1'b0, 32'd10,         32'd8,          1'b0, 1'b1, 8'd4,  32'd1, 1'b0},
    '{1'b1, 32'd5,          32'd2,          1'b1, 1'b0, 8'd20, 32'd2, 1'b0},
    '{1'b1, 32'hFFFF_FFFF,  32'hFFFF_FFFD,  1'b0, 1'b1, 8'd5,  32'd2, 1'b0},
    '{1'b0, 32'd0,          32'd0,          1'b1, 1'b1, 8'd3,  32'd0, 1'b1},
    '{1'b1, 32'd3,          32'd0,          1'b1, 1'b1, 8'd9,  32'd1, 1'b1},
    '{1'b0, 32'd4,          32'd6,          1'b1, 1'b1, 8'd3,  32'd9, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        halted = 1'b1;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  pdt_dual_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .halted_i(halted), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, a0;
    logic [11:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(T0, v);        check("R1 t0 count reset", v, 32'd0);
    rd(T0 + 12'd2, v); check("R1 t0 limit reset", v, 32'hFFFF_FFFF);
    rd(T1 + 12'd2, v); check("R1 t1 limit reset", v, 32'hFFFF_FFFF);
    rd(T0 + 12'd1, v); check("R1 t0 ctrl reset", v, 32'd0);
    check("R1 irq reset", {30'd0, irq}, 32'd0);

    // R4 halted ignored while gating bit is 0
    repeat (3) @(negedge clk);
    rd(T0, v); check("R4 halt ignored", v, 32'd3);

    // R7 control readback and unmapped reads
    wr(T0 + 12'd1, 32'hFFFF_FFFF);
    rd(T0 + 12'd1, v); check("R7 ctrl upper zero", v, 32'd3);
    rd(12'h024, v); check("R7 unmapped 0x024", v, 32'd0);
    rd(12'h020, v); check("R7 unmapped 0x020", v, 32'd0);
    rd(12'h103, v); check("R7 unmapped 0x103", v, 32'd0);

    // R2 count write wins over step
    wr(T0 + 12'd1, 32'd0);
    wr(T0, 32'd100);
    rd(T0, v); check("R2 write over step", v, 32'd100);
    @(negedge clk);
    rd(T0, v); check("R2 step after write", v, 32'd101);

    // R2 count write suppresses reload and flag
    wr(T0 + 12'd1, 32'd2);
    wr(T0 + 12'd2, 32'd5);
    wr(T0, 32'd5);
    wr(T0 + 12'd1, 32'd3);
    @(negedge clk);
    addr = T0; wdata = 32'd2; we = 1'b1; halted = 1'b0;
    @(negedge clk);
    we = 1'b0; halted = 1'b1;
    rd(T0, v); check("R2 write over reload", v, 32'd2);
    check("R2 no flag on overridden reload", {31'd0, irq[0]}, 32'd0);

    // R6 clear on control write, clear wins over reload
    wr(T0 + 12'd1, 32'd2);
    wr(T0 + 12'd2, 32'd0);
    wr(T0, 32'd0);
    wr(T0 + 12'd1, 32'd1);
    check("R6 cleared after write", {31'd0, irq[0]}, 32'd0);
    @(negedge clk);
    check("R3 reload at limit 0 sets irq", {31'd0, irq[0]}, 32'd1);
    wr(T0 + 12'd1, 32'd1);
    check("R6 clear wins over reload", {31'd0, irq[0]}, 32'd0);
    @(negedge clk);
    check("R6 flag returns", {31'd0, irq[0]}, 32'd1);

    // R5 sticky with no further reload
    wr(T0 + 12'd2, 32'd1000);
    repeat (10) @(negedge clk);
    check("R5 sticky flag", {31'd0, irq[0]}, 32'd1);

    // R8 independence
    wr(T1 + 12'd1, 32'd2);
    wr(T1, 32'd55);
    check("R8 t1 ctrl write keeps t0 irq", {31'd0, irq[0]}, 32'd1);
    rd(T0, a0);
    repeat (4) @(negedge clk);
    rd(T0, v); check("R8 t0 runs", v, a0 + 32'd4);
    rd(T1, v); check("R8 t1 frozen", v, 32'd55);
    check("R8 t1 irq clear", {31'd0, irq[1]}, 32'd0);

    // table walk: R3 R4 R5 with gating mode on
    for (int i = 0; i < 8; i++) begin
      base = VEC[i].tmr ? T1 : T0;
      halted = 1'b1;
      wr(base + 12'd1, 32'd2);
      wr(base + 12'd2, VEC[i].lim);
      wr(base, VEC[i].cnt);
      wr(base + 12'd1, {30'd0, 1'b1, VEC[i].ie});
      halted = !VEC[i].run;
      repeat (int'(VEC[i].n)) @(negedge clk);
      halted = 1'b1;
      rd(base, v);
      check($sformatf("R3 R4 vec%0d count", i), v, VEC[i].exp_cnt);
      check($sformatf("R5 vec%0d irq", i), {31'd0, irq[VEC[i].tmr]}, {31'd0, VEC[i].exp_irq});
    end

    finish_run();
  end
endmodule